// File: doc/BRIEF.md
# Serial Port Clock and Frame Sync Router

This block sits between the pads of an audio serial port and its transmit and receive engines. For each of the four timing lines it chooses where the internal signal comes from: the transmit bit clock, the receive bit clock, the transmit frame sync and the receive frame sync. A line is either taken from its pad, with optional inversion, or taken from the internal clock and frame generator. When a line is generated internally, the block also drives the pad and its output enable, inverted as configured. The engines always see a rising-edge transmit clock and active-high frame syncs, whatever the polarity on the pads.

When the transmit frame sync is internal and the generator frame mode is off, each copy of the transmit holding buffer into the shifter arms a small pulse stretcher. At the next transmit bit tick, the stretcher raises the frame sync for `PULSE_BITS` bit periods. A loopback mode feeds the receive side from the transmit clock, the transmit frame sync and the transmit data. A combinational status bit flags loopback requested with an illegal setup.

Top module: `clkfs_router`

## Requirements
- R1: With `txc_drive`=0 the internal transmit clock equals `pin_txc_i` XOR `txc_inv` and `pin_txc_oe` is 0. With `txc_drive`=1 the internal transmit clock equals `gen_clk`, `pin_txc_oe` is 1 and `pin_txc_o` equals `gen_clk` XOR `txc_inv`.
- R2: The receive clock follows the same rule through `rxc_drive`, `rxc_inv`, `pin_rxc_i`, `pin_rxc_o` and `pin_rxc_oe`, when loopback is off.
- R3: An input frame sync (`txf_drive`/`rxf_drive`=0) reaches the engine as the pad value XOR its polarity bit. With the polarity bit at 1, an active-low pad pulse therefore becomes an active-high internal sync.
- R4: A driven frame sync pad (`*_drive`=1) carries the internal active-high sync XOR its polarity bit, and its output enable is 1.
- R5: With `loopback`=1 the internal receive clock, receive frame sync and receive data equal the internal transmit clock, transmit frame sync and `tx_data`. With loopback off, receive data equals `pin_rxd_i`.
- R6: With `loopback`=1 and `rxc_drive`=0, `pin_rxc_oe` is 0. With `loopback`=1 and `rxf_drive`=0, `pin_rxf_oe` is 0.
- R7: With `txf_drive`=1 and `gen_fs_mode`=0, a one-cycle `copy_pulse` raises the transmit frame sync at the clock edge of the next `bit_tick`. This includes a tick in the same cycle as the copy. The sync falls at the edge of the `PULSE_BITS`-th tick after that (default 1, one bit period). Between ticks the sync holds its level.
- R8: With `txf_drive`=1 and `gen_fs_mode`=1 the internal transmit frame sync equals `gen_fs`, and copy pulses have no effect on it.
- R9: `cfg_err` is 1 exactly when `loopback`=1 and any of `txc_drive`=0, `txf_drive`=0 or `clk_stop`=1 holds.
- R10: After reset the stretcher is idle: a driven transmit frame sync from the stretcher is 0 until a copy and a tick occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the stretcher |
| rst_n | input | 1 | Active-low asynchronous reset |
| txc_drive | input | 1 | 1: transmit clock from generator, pad driven |
| rxc_drive | input | 1 | 1: receive clock from generator, pad driven |
| txf_drive | input | 1 | 1: transmit frame sync internal, pad driven |
| rxf_drive | input | 1 | 1: receive frame sync from generator, pad driven |
| txc_inv | input | 1 | Transmit clock pad polarity |
| rxc_inv | input | 1 | Receive clock pad polarity |
| txf_inv | input | 1 | Transmit frame sync pad polarity |
| rxf_inv | input | 1 | Receive frame sync pad polarity |
| loopback | input | 1 | Feed receive side from transmit side |
| gen_fs_mode | input | 1 | 1: internal transmit sync from generator, 0: from copy pulses |
| clk_stop | input | 1 | Clock-stop mode active |
| pin_txc_i | input | 1 | Transmit clock pad input |
| pin_rxc_i | input | 1 | Receive clock pad input |
| pin_txf_i | input | 1 | Transmit frame sync pad input |
| pin_rxf_i | input | 1 | Receive frame sync pad input |
| pin_rxd_i | input | 1 | Receive data pad input |
| gen_clk | input | 1 | Generator bit clock |
| gen_fs | input | 1 | Generator frame sync |
| copy_pulse | input | 1 | One-cycle strobe: holding buffer copied to shifter |
| bit_tick | input | 1 | One-cycle strobe at each transmit bit period start |
| tx_data | input | 1 | Internal serial transmit data |
| pin_txc_o | output | 1 | Transmit clock pad output |
| pin_txc_oe | output | 1 | Transmit clock pad enable |
| pin_rxc_o | output | 1 | Receive clock pad output |
| pin_rxc_oe | output | 1 | Receive clock pad enable |
| pin_txf_o | output | 1 | Transmit frame sync pad output |
| pin_txf_oe | output | 1 | Transmit frame sync pad enable |
| pin_rxf_o | output | 1 | Receive frame sync pad output |
| pin_rxf_oe | output | 1 | Receive frame sync pad enable |
| tx_clk_int | output | 1 | Internal transmit bit clock |
| rx_clk_int | output | 1 | Internal receive bit clock |
| tx_fs_int | output | 1 | Internal transmit frame sync, active high |
| rx_fs_int | output | 1 | Internal receive frame sync, active high |
| rx_data_int | output | 1 | Internal receive data |
| cfg_err | output | 1 | Illegal loopback configuration |

## Verification
Every routing result (R1 to R6, R8, R9) is combinational, so it is due in the same cycle as its stimulus. The bench changes inputs on the falling clock edge and samples two nanoseconds later, before the next rising edge. The stretcher output (R7, R10) is registered once. It changes at the rising edge that samples `bit_tick` together with an armed copy. The bench therefore reads it at the following falling edge, and it checks that the sync holds in the tick-free cycles in between. Polarity and loopback cases are each covered with both values of the relevant configuration bit.

// File: rtl/clkfs_pkg.sv
package clkfs_pkg;

   // Pad polarity: a set bit inverts between the pad and the active-high
   // internal domain, in either direction.
   function automatic logic pad_polarity(input logic sig, input logic inv);
      return sig ^ inv;
   endfunction

endpackage

// File: rtl/pin_route_cell.sv
module pin_route_cell
   import clkfs_pkg::*;
(
   input  logic pin_i,
   input  logic gen_sig,
   input  logic alt_sig,
   input  logic use_alt,
   input  logic drive,
   input  logic inv,
   output logic int_sig,
   output logic pin_o,
   output logic pin_oe
);

   logic from_pad;

   // Pad-sourced value converted into the internal convention.
   assign from_pad = pad_polarity(pin_i, inv);

   always_comb begin
      if (use_alt)
         int_sig = alt_sig;
      else if (drive)
         int_sig = gen_sig;
      else
         int_sig = from_pad;
   end

   // The pad only ever carries the internal value, re-inverted; with the
   // enable low the pad is an input (high impedance from this side).
   assign pin_o  = pad_polarity(int_sig, inv);
   assign pin_oe = drive;

endmodule

// File: rtl/fs_stretch.sv
module fs_stretch #(
   parameter int PULSE_BITS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic copy_i,
   input  logic tick_i,
   output logic fs_o
);

   logic pend_q;
   logic act_q;
   logic start;

   initial assert (PULSE_BITS >= 1) else $error("PULSE_BITS must be at least 1");

   // A pending or same-cycle copy launches the pulse at a bit tick.
   assign start = tick_i & (pend_q | copy_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (start)
         pend_q <= 1'b0;
      else if (copy_i)
         pend_q <= 1'b1;
   end

   generate
      if (PULSE_BITS == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               act_q <= 1'b0;
            else if (start)
               act_q <= 1'b1;
            else if (tick_i)
               act_q <= 1'b0;
         end

         // R7: an active pulse ends at the next tick that does not restart it
         p_single_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (act_q && tick_i && !start) |=> !act_q);
      end else begin : g_count
         localparam int CW = $clog2(PULSE_BITS);
         logic [CW-1:0] left_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_q  <= 1'b0;
               left_q <= '0;
            end else if (start) begin
               act_q  <= 1'b1;
               left_q <= CW'(PULSE_BITS - 1);
            end else if (tick_i && act_q) begin
               if (left_q == '0)
                  act_q <= 1'b0;
               else
                  left_q <= left_q - 1'b1;
            end
         end

         // R7: the pulse never ends while bit periods remain
         p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (act_q && (left_q != '0) && !start) |=> act_q);
      end
   endgenerate

   assign fs_o = act_q;

   // R7: a launched pulse is visible after the launching edge
   p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> fs_o);

   // R7: without a tick the pulse level cannot change
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(fs_o));

endmodule

// File: rtl/clkfs_router.sv
module clkfs_router
   import clkfs_pkg::*;
#(
   parameter int PULSE_BITS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic txc_drive,
   input  logic rxc_drive,
   input  logic txf_drive,
   input  logic rxf_drive,
   input  logic txc_inv,
   input  logic rxc_inv,
   input  logic txf_inv,
   input  logic rxf_inv,
   input  logic loopback,
   input  logic gen_fs_mode,
   input  logic clk_stop,
   input  logic pin_txc_i,
   input  logic pin_rxc_i,
   input  logic pin_txf_i,
   input  logic pin_rxf_i,
   input  logic pin_rxd_i,
   input  logic gen_clk,
   input  logic gen_fs,
   input  logic copy_pulse,
   input  logic bit_tick,
   input  logic tx_data,
   output logic pin_txc_o,
   output logic pin_txc_oe,
   output logic pin_rxc_o,
   output logic pin_rxc_oe,
   output logic pin_txf_o,
   output logic pin_txf_oe,
   output logic pin_rxf_o,
   output logic pin_rxf_oe,
   output logic tx_clk_int,
   output logic rx_clk_int,
   output logic tx_fs_int,
   output logic rx_fs_int,
   output logic rx_data_int,
   output logic cfg_err
);

   logic stretch_fs;
   logic tx_fs_src;

   fs_stretch #(.PULSE_BITS(PULSE_BITS)) u_stretch (
      .clk    (clk),
      .rst_n  (rst_n),
      .copy_i (copy_pulse),
      .tick_i (bit_tick),
      .fs_o   (stretch_fs)
   );

   // Internal transmit sync source: generator frame or copy-driven pulse.
   assign tx_fs_src = gen_fs_mode ? gen_fs : stretch_fs;

   pin_route_cell u_txc (
      .pin_i (pin_txc_i), .gen_sig (gen_clk), .alt_sig (1'b0), .use_alt (1'b0),
      .drive (txc_drive), .inv (txc_inv),
      .int_sig (tx_clk_int), .pin_o (pin_txc_o), .pin_oe (pin_txc_oe)
   );

   pin_route_cell u_txf (
      .pin_i (pin_txf_i), .gen_sig (tx_fs_src), .alt_sig (1'b0), .use_alt (1'b0),
      .drive (txf_drive), .inv (txf_inv),
      .int_sig (tx_fs_int), .pin_o (pin_txf_o), .pin_oe (pin_txf_oe)
   );

   pin_route_cell u_rxc (
      .pin_i (pin_rxc_i), .gen_sig (gen_clk), .alt_sig (tx_clk_int), .use_alt (loopback),
      .drive (rxc_drive), .inv (rxc_inv),
      .int_sig (rx_clk_int), .pin_o (pin_rxc_o), .pin_oe (pin_rxc_oe)
   );

   pin_route_cell u_rxf (
      .pin_i (pin_rxf_i), .gen_sig (gen_fs), .alt_sig (tx_fs_int), .use_alt (loopback),
      .drive (rxf_drive), .inv (rxf_inv),
      .int_sig (rx_fs_int), .pin_o (pin_rxf_o), .pin_oe (pin_rxf_oe)
   );

   assign rx_data_int = loopback ? tx_data : pin_rxd_i;

   assign cfg_err = loopback & (~txc_drive | ~txf_drive | clk_stop);

   // R5: the receive side mirrors the transmit side in loopback
   p_loop_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
      loopback |-> (rx_clk_int == tx_clk_int) && (rx_fs_int == tx_fs_int));

   // R6: receive pads configured as inputs stay undriven in loopback
   p_loop_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (loopback && !rxc_drive) |-> !pin_rxc_oe);

   // R4: a driven transmit sync pad carries the internal sync with polarity
   p_fs_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (txf_drive && pin_txf_oe) |-> (pin_txf_o == (tx_fs_int ^ txf_inv)));

   // R8: generator frame mode passes the generator sync straight through
   p_gen_fs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (txf_drive && gen_fs_mode) |-> (tx_fs_int == gen_fs));

   // R9: no error is ever flagged outside loopback
   p_err_loop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> loopback);

endmodule

// File: tb/sim_clkfs_router.sv
module sim_clkfs_router;

   logic clk = 1'b0;
   logic rst_n;
   logic txc_drive, rxc_drive, txf_drive, rxf_drive;
   logic txc_inv, rxc_inv, txf_inv, rxf_inv;
   logic loopback, gen_fs_mode, clk_stop;
   logic pin_txc_i, pin_rxc_i, pin_txf_i, pin_rxf_i, pin_rxd_i;
   logic gen_clk, gen_fs, copy_pulse, bit_tick, tx_data;
   logic pin_txc_o, pin_txc_oe, pin_rxc_o, pin_rxc_oe;
   logic pin_txf_o, pin_txf_oe, pin_rxf_o, pin_rxf_oe;
   logic tx_clk_int, rx_clk_int, tx_fs_int, rx_fs_int, rx_data_int, cfg_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   clkfs_router u0 (.*);

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic settle();
      #2;
   endtask

   task automatic defaults();
      {txc_drive, rxc_drive, txf_drive, rxf_drive} = 4'b0;
      {txc_inv, rxc_inv, txf_inv, rxf_inv} = 4'b0;
      {loopback, gen_fs_mode, clk_stop} = 3'b0;
      {pin_txc_i, pin_rxc_i, pin_txf_i, pin_rxf_i, pin_rxd_i} = 5'b0;
      {gen_clk, gen_fs, copy_pulse, bit_tick, tx_data} = 5'b0;
   endtask

   task automatic t_reset();
      step(); txf_drive = 1'b1; txf_inv = 1'b1; settle();
      check("R10 sync idle after reset", tx_fs_int, 1'b0);
      check("R10 pad idle after reset", pin_txf_o, 1'b1);
      txf_drive = 1'b0; txf_inv = 1'b0;
   endtask

   task automatic t_tx_clock();
      for (int v = 0; v < 8; v++) begin
         step();
         txc_drive = v[2]; txc_inv = v[1]; pin_txc_i = v[0]; gen_clk = ~v[0];
         settle();
         if (v[2]) begin
            check("R1 int clk from generator", tx_clk_int, gen_clk);
            check("R1 pad out", pin_txc_o, gen_clk ^ v[1]);
            check("R1 pad enable", pin_txc_oe, 1'b1);
         end else begin
            check("R1 int clk from pad", tx_clk_int, v[0] ^ v[1]);
            check("R1 pad enable off", pin_txc_oe, 1'b0);
         end
      end
      txc_drive = 1'b0; txc_inv = 1'b0;
   endtask

   task automatic t_rx_clock();
      for (int v = 0; v < 8; v++) begin
         step();
         rxc_drive = v[2]; rxc_inv = v[1]; pin_rxc_i = v[0]; gen_clk = v[0];
         settle();
         if (v[2]) begin
            check("R2 int clk from generator", rx_clk_int, gen_clk);
            check("R2 pad out", pin_rxc_o, gen_clk ^ v[1]);
            check("R2 pad enable", pin_rxc_oe, 1'b1);
         end else begin
            check("R2 int clk from pad", rx_clk_int, v[0] ^ v[1]);
            check("R2 pad enable off", pin_rxc_oe, 1'b0);
         end
      end
      rxc_drive = 1'b0; rxc_inv = 1'b0;
   endtask

   task automatic t_fs_input();
      step(); txf_inv = 1'b1; rxf_inv = 1'b1; pin_txf_i = 1'b0; pin_rxf_i = 1'b0; settle();
      check("R3 active-low tx sync seen high", tx_fs_int, 1'b1);
      check("R3 active-low rx sync seen high", rx_fs_int, 1'b1);
      step(); pin_txf_i = 1'b1; pin_rxf_i = 1'b1; settle();
      check("R3 idle tx sync low", tx_fs_int, 1'b0);
      check("R3 idle rx sync low", rx_fs_int, 1'b0);
      step(); txf_inv = 1'b0; rxf_inv = 1'b0; settle();
      check("R3 non-inverted tx sync", tx_fs_int, 1'b1);
      check("R3 non-inverted rx sync", rx_fs_int, 1'b1);
      pin_txf_i = 1'b0; pin_rxf_i = 1'b0;
   endtask

   task automatic t_fs_output_gen();
      step(); txf_drive = 1'b1; rxf_drive = 1'b1; gen_fs_mode = 1'b1;
      txf_inv = 1'b1; rxf_inv = 1'b0; gen_fs = 1'b1; settle();
      check("R8 tx sync from generator", tx_fs_int, 1'b1);
      check("R4 tx pad inverted", pin_txf_o, 1'b0);
      check("R4 tx pad enable", pin_txf_oe, 1'b1);
      check("R4 rx pad plain", pin_rxf_o, 1'b1);
      check("R4 rx pad enable", pin_rxf_oe, 1'b1);
      // copy pulses are ignored in generator frame mode
      step(); gen_fs = 1'b0; copy_pulse = 1'b1; bit_tick = 1'b1;
      step(); copy_pulse = 1'b0; bit_tick = 1'b0; settle();
      check("R8 copy ignored", tx_fs_int, 1'b0);
      check("R8 copy ignored on pad", pin_txf_o, 1'b1);
      step(); gen_fs_mode = 1'b0; settle();
      check("R7 stretcher fired while hidden", tx_fs_int, 1'b1);
      step(); bit_tick = 1'b1; step(); bit_tick = 1'b0; settle();
      check("R7 hidden pulse ended", tx_fs_int, 1'b0);
      rxf_drive = 1'b0; txf_inv = 1'b0;
   endtask

   task automatic t_stretch();
      step(); txf_drive = 1'b1; gen_fs_mode = 1'b0; copy_pulse = 1'b1;
      step(); copy_pulse = 1'b0; settle();
      check("R7 no sync before tick", tx_fs_int, 1'b0);
      step(); settle();
      check("R7 still armed, no sync", tx_fs_int, 1'b0);
      step(); bit_tick = 1'b1;
      step(); bit_tick = 1'b0; settle();
      check("R7 sync raised at tick", tx_fs_int, 1'b1);
      check("R7 sync on pad", pin_txf_o, 1'b1);
      step(); step(); settle();
      check("R7 sync held between ticks", tx_fs_int, 1'b1);
      step(); bit_tick = 1'b1;
      step(); bit_tick = 1'b0; settle();
      check("R7 sync one bit wide", tx_fs_int, 1'b0);
      step(); bit_tick = 1'b1; copy_pulse = 1'b1;
      step(); bit_tick = 1'b0; copy_pulse = 1'b0; settle();
      check("R7 same-cycle copy and tick", tx_fs_int, 1'b1);
      step(); bit_tick = 1'b1;
      step(); bit_tick = 1'b0; settle();
      check("R7 same-cycle pulse ends", tx_fs_int, 1'b0);
      step(); bit_tick = 1'b1;
      step(); bit_tick = 1'b0; settle();
      check("R7 no pulse without copy", tx_fs_int, 1'b0);
   endtask

   task automatic t_loopback();
      step(); loopback = 1'b1; txc_drive = 1'b1; txf_drive = 1'b1; gen_fs_mode = 1'b1;
      rxc_drive = 1'b0; rxf_drive = 1'b0; gen_clk = 1'b1; gen_fs = 1'b1;
      tx_data = 1'b1; pin_rxd_i = 1'b0; pin_rxc_i = 1'b0; pin_rxf_i = 1'b0; settle();
      check("R5 rx clk from tx", rx_clk_int, 1'b1);
      check("R5 rx sync from tx", rx_fs_int, 1'b1);
      check("R5 rx data from tx", rx_data_int, 1'b1);
      check("R6 rx clk pad undriven", pin_rxc_oe, 1'b0);
      check("R6 rx sync pad undriven", pin_rxf_oe, 1'b0);
      check("R9 legal loopback", cfg_err, 1'b0);
      step(); gen_clk = 1'b0; gen_fs = 1'b0; tx_data = 1'b0; pin_rxd_i = 1'b1; settle();
      check("R5 rx clk follows low", rx_clk_int, 1'b0);
      check("R5 rx data follows low", rx_data_int, 1'b0);
      step(); loopback = 1'b0; settle();
      check("R5 rx data from pad", rx_data_int, 1'b1);
      check("R9 no loopback no error", cfg_err, 1'b0);
   endtask

   task automatic t_cfg_err();
      step(); loopback = 1'b1; txc_drive = 1'b0; txf_drive = 1'b1; clk_stop = 1'b0; settle();
      check("R9 tx clk input", cfg_err, 1'b1);
      step(); txc_drive = 1'b1; txf_drive = 1'b0; settle();
      check("R9 tx sync input", cfg_err, 1'b1);
      step(); txf_drive = 1'b1; clk_stop = 1'b1; settle();
      check("R9 clock stop", cfg_err, 1'b1);
      step(); loopback = 1'b0; txc_drive = 1'b0; settle();
      check("R9 error needs loopback", cfg_err, 1'b0);
      clk_stop = 1'b0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      defaults();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_tx_clock();
      t_rx_clock();
      t_fs_input();
      t_fs_output_gen();
      t_stretch();
      t_loopback();
      t_cfg_err();
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule